// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for a shared on-chip packet RAM that is divided into fixed-size pages. Transmit and receive traffic both draw from the same pool, and the pool has no fixed split between them. A requester asks for a packet of a given number of pages. The allocator reserves that many free pages, which need not be contiguous, and returns a packet number. It also records the packet's page list, so that later accesses can turn a logical page offset inside the packet into a physical page.

Releasing a packet number returns all of its pages to the pool and makes the number available again. A combinational translation port maps a (packet, offset) pair to a physical page, together with a validity flag. The current number of free pages is always visible on an output. The RAM itself, the MAC and the host bus sit outside this block.

With the default parameters there are 24 pages of 256 bytes and 24 packet numbers 5 bits wide, and one packet may hold 1 to 6 pages.

Top module: `pgbuf_alloc`

## Requirements
- R1: After reset, `free_count` is 24, no outcome pulse is raised, and every translation returns `xl_valid` = 0.
- R2: A granted allocation of N pages takes the N lowest-numbered free pages. Translating offset k of that packet returns the (k+1)-th lowest of those pages, and `free_count` drops by N.
- R3: A grant returns the lowest packet number that is not currently in use on `alloc_pkt`.
- R4: A request for 0 pages, or for more than 6 pages, raises `alloc_err` and changes no pages and no packet numbers.
- R5: If fewer pages are free than requested, `alloc_deny` is raised and no page is assigned, so `free_count` is unchanged.
- R6: Releasing an in-use packet returns all of its pages: `free_count` rises by its page count, its translations become invalid, and its number can be handed out again.
- R7: `xl_valid` is 0 when the offset is at or beyond the packet's page count, or when the packet is not in use.
- R8: When a release and an allocation arrive in the same cycle, the release is applied first. Its pages and its packet number are available to that allocation.
- R9: Exactly one of `alloc_grant`, `alloc_deny` and `alloc_err` pulses for one cycle, in the cycle after a sampled request. None of them is raised otherwise.
- R10: A release naming a packet number that is not in use, including one of 24 or above, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request, sampled on the clock edge |
| alloc_pages | input | 3 | Number of pages requested |
| alloc_grant | output | 1 | Allocation succeeded (one-cycle pulse) |
| alloc_deny | output | 1 | Not enough free pages (one-cycle pulse) |
| alloc_err | output | 1 | Illegal page count (one-cycle pulse) |
| alloc_pkt | output | 5 | Packet number given by the last grant |
| rel_req | input | 1 | Release request |
| rel_pkt | input | 5 | Packet number to release |
| xl_pkt | input | 5 | Packet number to translate |
| xl_ofs | input | 3 | Page offset inside the packet |
| xl_page | output | 5 | Physical page for the translation |
| xl_valid | output | 1 | Translation is valid |
| free_count | output | 5 | Number of free pages |

## Verification
A corrupted free bitmap shows at the ports in the very next cycle. `free_count` goes wrong, or a later grant hands out a page that the translation port already reports for another packet. A stale page list or page count appears only when that packet is translated or released: a wrong physical page, a wrong validity flag, or a free count that does not come back to 24 once every packet has been released. The bench therefore translates every offset after each grant and drains the pool completely, so that damaged state cannot stay hidden.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   localparam int unsigned PAGES_DEF   = 24;
   localparam int unsigned PKTS_DEF    = 24;
   localparam int unsigned MAXPP_DEF   = 6;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pgbuf_pick.sv
module pgbuf_pick #(
   parameter int unsigned N   = 24,
   parameter int unsigned SEL = 6,
   parameter int unsigned W   = 5
) (
   input  logic [N-1:0]          avail,
   output logic [SEL-1:0][W-1:0] idx,
   output logic [SEL-1:0]        found
);
   logic [N-1:0] rem [SEL+1];

   assign rem[0] = avail;

   for (genvar k = 0; k < SEL; k++) begin : g_stage
      always_comb begin
         idx[k]   = '0;
         found[k] = 1'b0;
         for (int b = N - 1; b >= 0; b--) begin
            if (rem[k][b]) begin
               idx[k]   = W'(b);
               found[k] = 1'b1;
            end
         end
      end
      assign rem[k+1] = rem[k] & (rem[k] - 1'b1);
   end

   initial begin
      assert (SEL >= 1 && SEL <= N) else $error("pgbuf_pick: SEL out of range");
      assert ((1 << W) >= N) else $error("pgbuf_pick: W too narrow");
   end
endmodule

// File: rtl/pgbuf_tbl.sv
module pgbuf_tbl #(
   parameter int unsigned NUM_PAGES = 24,
   parameter int unsigned NUM_PKTS  = 24,
   parameter int unsigned MAX_PP    = 6,
   parameter int unsigned PAGE_W    = 5,
   parameter int unsigned PKT_W     = 5,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned OFS_W     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [PKT_W-1:0]              wr_pkt,
   input  logic [CNT_W-1:0]              wr_cnt,
   input  logic [MAX_PP-1:0][PAGE_W-1:0] wr_pages,
   input  logic                          rel_en,
   input  logic [PKT_W-1:0]              rel_pkt,
   output logic [NUM_PAGES-1:0]          rel_mask,
   input  logic [PKT_W-1:0]              xl_pkt,
   input  logic [OFS_W-1:0]              xl_ofs,
   output logic [PAGE_W-1:0]             xl_page,
   output logic                          xl_valid
);
   logic [MAX_PP-1:0][PAGE_W-1:0] list_q [NUM_PKTS];
   logic [CNT_W-1:0]              cnt_q  [NUM_PKTS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < int'(NUM_PKTS); p++) begin
            cnt_q[p]  <= '0;
            list_q[p] <= '0;
         end
      end else begin
         if (rel_en && int'(rel_pkt) < int'(NUM_PKTS))
            cnt_q[rel_pkt] <= '0;
         if (wr_en && int'(wr_pkt) < int'(NUM_PKTS)) begin
            cnt_q[wr_pkt]  <= wr_cnt;
            list_q[wr_pkt] <= wr_pages;
         end
      end
   end

   always_comb begin
      rel_mask = '0;
      if (int'(rel_pkt) < int'(NUM_PKTS)) begin
         for (int i = 0; i < int'(MAX_PP); i++) begin
            if (i < int'(cnt_q[rel_pkt]))
               rel_mask[list_q[rel_pkt][i]] = 1'b1;
         end
      end
   end

   always_comb begin
      xl_page  = '0;
      xl_valid = 1'b0;
      if (int'(xl_pkt) < int'(NUM_PKTS) && int'(xl_ofs) < int'(MAX_PP)) begin
         if (int'(xl_ofs) < int'(cnt_q[xl_pkt])) begin
            xl_valid = 1'b1;
            xl_page  = list_q[xl_pkt][xl_ofs];
         end
      end
   end

   assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> xl_valid || xl_pkt != $past(wr_pkt) || xl_ofs != '0)
      else $error("assert_write_visible_R2");
endmodule

// File: rtl/pgbuf_alloc.sv
module pgbuf_alloc
   import pgbuf_pkg::*;
#(
   parameter int unsigned NUM_PAGES = PAGES_DEF,
   parameter int unsigned NUM_PKTS  = PKTS_DEF,
   parameter int unsigned MAX_PP    = MAXPP_DEF,
   localparam int unsigned PAGE_W   = bits_for(NUM_PAGES),
   localparam int unsigned PKT_W    = bits_for(NUM_PKTS),
   localparam int unsigned CNT_W    = bits_for(MAX_PP + 1),
   localparam int unsigned OFS_W    = bits_for(MAX_PP),
   localparam int unsigned FREE_W   = bits_for(NUM_PAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic [CNT_W-1:0]  alloc_pages,
   output logic              alloc_grant,
   output logic              alloc_deny,
   output logic              alloc_err,
   output logic [PKT_W-1:0]  alloc_pkt,
   input  logic              rel_req,
   input  logic [PKT_W-1:0]  rel_pkt,
   input  logic [PKT_W-1:0]  xl_pkt,
   input  logic [OFS_W-1:0]  xl_ofs,
   output logic [PAGE_W-1:0] xl_page,
   output logic              xl_valid,
   output logic [FREE_W-1:0] free_count
);
   logic [NUM_PAGES-1:0] free_q, free_after, take_mask, rel_mask;
   logic [NUM_PKTS-1:0]  inuse_q, inuse_after;
   logic                 rel_hit, req_bad, enough;
   logic                 grant_d, deny_d, err_d;
   logic [MAX_PP-1:0][PAGE_W-1:0] page_idx;
   logic [MAX_PP-1:0]             page_found;
   logic [0:0][PKT_W-1:0]         pkt_idx;
   logic [0:0]                    pkt_found;

   // release is resolved first so its pages feed the same-cycle allocation
   assign rel_hit = rel_req && int'(rel_pkt) < int'(NUM_PKTS) && inuse_q[rel_pkt];

   always_comb begin
      free_after  = free_q;
      inuse_after = inuse_q;
      if (rel_hit) begin
         free_after           = free_q | rel_mask;
         inuse_after[rel_pkt] = 1'b0;
      end
   end

   pgbuf_pick #(.N(NUM_PAGES), .SEL(MAX_PP), .W(PAGE_W)) page_pick_i (
      .avail (free_after),
      .idx   (page_idx),
      .found (page_found)
   );

   pgbuf_pick #(.N(NUM_PKTS), .SEL(1), .W(PKT_W)) pkt_pick_i (
      .avail (~inuse_after),
      .idx   (pkt_idx),
      .found (pkt_found)
   );

   assign req_bad = (alloc_pages == '0) || (int'(alloc_pages) > int'(MAX_PP));
   assign enough  = ($countones(free_after) >= int'(alloc_pages)) && pkt_found[0];
   assign grant_d = alloc_req && !req_bad && enough;
   assign deny_d  = alloc_req && !req_bad && !enough;
   assign err_d   = alloc_req && req_bad;

   always_comb begin
      take_mask = '0;
      for (int k = 0; k < int'(MAX_PP); k++) begin
         if (k < int'(alloc_pages) && page_found[k])
            take_mask[page_idx[k]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q      <= '1;
         inuse_q     <= '0;
         alloc_grant <= 1'b0;
         alloc_deny  <= 1'b0;
         alloc_err   <= 1'b0;
         alloc_pkt   <= '0;
      end else begin
         alloc_grant <= grant_d;
         alloc_deny  <= deny_d;
         alloc_err   <= err_d;
         if (grant_d) begin
            free_q             <= free_after & ~take_mask;
            inuse_q            <= inuse_after;
            inuse_q[pkt_idx[0]] <= 1'b1;
            alloc_pkt          <= pkt_idx[0];
         end else begin
            free_q  <= free_after;
            inuse_q <= inuse_after;
         end
      end
   end

   pgbuf_tbl #(
      .NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS), .MAX_PP(MAX_PP),
      .PAGE_W(PAGE_W), .PKT_W(PKT_W), .CNT_W(CNT_W), .OFS_W(OFS_W)
   ) tbl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (grant_d),
      .wr_pkt   (pkt_idx[0]),
      .wr_cnt   (alloc_pages),
      .wr_pages (page_idx),
      .rel_en   (rel_hit),
      .rel_pkt  (rel_pkt),
      .rel_mask (rel_mask),
      .xl_pkt   (xl_pkt),
      .xl_ofs   (xl_ofs),
      .xl_page  (xl_page),
      .xl_valid (xl_valid)
   );

   assign free_count = FREE_W'($countones(free_q));

   initial begin
      assert (MAX_PP >= 1 && MAX_PP <= NUM_PAGES) else $error("pgbuf_alloc: MAX_PP out of range");
      assert (NUM_PKTS >= 1) else $error("pgbuf_alloc: NUM_PKTS must be positive");
   end

   assert property (@(posedge clk) disable iff (!rst_n)
      $countones({alloc_grant, alloc_deny, alloc_err}) <= 1)
      else $error("assert_outcome_exclusive_R9");

   assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |-> $past(alloc_req) &&
                    ($past(alloc_pages) == '0 || int'($past(alloc_pages)) > int'(MAX_PP)))
      else $error("assert_err_cause_R4");

   assert property (@(posedge clk) disable iff (!rst_n)
      alloc_deny |-> int'($past(alloc_pages)) > int'($past(free_count)) || $past(&inuse_q))
      else $error("assert_deny_short_R5");

   assert property (@(posedge clk) disable iff (!rst_n)
      alloc_grant && !$past(rel_req) |->
         int'(free_count) + int'($past(alloc_pages)) == int'($past(free_count)))
      else $error("assert_grant_count_R2");

   assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |-> !free_q[xl_page])
      else $error("assert_xl_page_owned_R7");

   assert property (@(posedge clk) disable iff (!rst_n)
      $past(rel_req) && !$past(rel_hit) && !$past(alloc_req) |-> $stable(free_count))
      else $error("assert_bad_release_ignored_R10");
endmodule

// File: tb/pgbuf_alloc_tb_top.sv
module pgbuf_alloc_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       alloc_req;
   logic [2:0] alloc_pages;
   logic       alloc_grant, alloc_deny, alloc_err;
   logic [4:0] alloc_pkt;
   logic       rel_req;
   logic [4:0] rel_pkt, xl_pkt;
   logic [2:0] xl_ofs;
   logic [4:0] xl_page;
   logic       xl_valid;
   logic [4:0] free_count;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pgbuf_alloc dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_req), .alloc_pages(alloc_pages),
      .alloc_grant(alloc_grant), .alloc_deny(alloc_deny), .alloc_err(alloc_err),
      .alloc_pkt(alloc_pkt),
      .rel_req(rel_req), .rel_pkt(rel_pkt),
      .xl_pkt(xl_pkt), .xl_ofs(xl_ofs), .xl_page(xl_page), .xl_valid(xl_valid),
      .free_count(free_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive one cycle of request, then sample registered outcome at next negedge
   task automatic step(input bit a, input int pages, input bit r, input int rp);
      alloc_req   = a;
      alloc_pages = 3'(pages);
      rel_req     = r;
      rel_pkt     = 5'(rp);
      @(posedge clk);
      @(negedge clk);
      alloc_req = 1'b0;
      rel_req   = 1'b0;
   endtask

   task automatic xl_check(input string req, input int pkt, input int ofs,
                           input int exp_v, input int exp_pg);
      xl_pkt = 5'(pkt);
      xl_ofs = 3'(ofs);
      #1;
      chk(req, int'(xl_valid), exp_v);
      if (exp_v != 0) chk(req, int'(xl_page), exp_pg);
   endtask

   task automatic grant_expect(input string req, input int pages, input int exp_pkt,
                               input int exp_free);
      step(1'b1, pages, 1'b0, 0);
      chk({req, " grant"}, int'(alloc_grant), 1);
      chk("R9 no deny", int'(alloc_deny), 0);
      chk("R3 pkt", int'(alloc_pkt), exp_pkt);
      chk({req, " free"}, int'(free_count), exp_free);
      @(negedge clk);
      chk("R9 pulse width", int'(alloc_grant), 0);
   endtask

   task automatic t_reset();
      chk("R1 free", int'(free_count), 24);
      chk("R1 grant", int'(alloc_grant | alloc_deny | alloc_err), 0);
      xl_check("R1 xl", 0, 0, 0, 0);
   endtask

   task automatic t_basic();
      grant_expect("R2", 3, 0, 21);
      for (int k = 0; k < 3; k++) xl_check("R2 xl", 0, k, 1, k);
      xl_check("R7 past end", 0, 3, 0, 0);
      grant_expect("R2", 2, 1, 19);
      xl_check("R2 xl", 1, 0, 1, 3);
      xl_check("R2 xl", 1, 1, 1, 4);
      xl_check("R7 unused pkt", 2, 0, 0, 0);
   endtask

   task automatic t_err();
      step(1'b1, 0, 1'b0, 0);
      chk("R4 zero err", int'(alloc_err), 1);
      chk("R4 zero grant", int'(alloc_grant), 0);
      step(1'b1, 7, 1'b0, 0);
      chk("R4 seven err", int'(alloc_err), 1);
      chk("R4 free kept", int'(free_count), 19);
      xl_check("R4 pkt2 unused", 2, 0, 0, 0);
   endtask

   task automatic t_release();
      step(1'b0, 0, 1'b1, 0);
      chk("R6 free back", int'(free_count), 22);
      xl_check("R6 xl invalid", 0, 0, 0, 0);
      grant_expect("R6 reuse", 4, 0, 18);
      xl_check("R2 noncontig", 0, 0, 1, 0);
      xl_check("R2 noncontig", 0, 2, 1, 2);
      xl_check("R2 noncontig", 0, 3, 1, 5);
      step(1'b0, 0, 1'b1, 9);
      chk("R10 free", int'(free_count), 18);
      step(1'b0, 0, 1'b1, 30);
      chk("R10 free hi", int'(free_count), 18);
      xl_check("R10 pkt1 kept", 1, 1, 1, 4);
   endtask

   task automatic t_deny();
      grant_expect("R2", 6, 2, 12);
      grant_expect("R2", 6, 3, 6);
      grant_expect("R2", 6, 4, 0);
      xl_check("R2 xl", 4, 5, 1, 23);
      step(1'b1, 1, 1'b0, 0);
      chk("R5 deny", int'(alloc_deny), 1);
      chk("R5 no grant", int'(alloc_grant), 0);
      chk("R5 free", int'(free_count), 0);
      xl_check("R5 pkt5 unused", 5, 0, 0, 0);
   endtask

   task automatic t_same_cycle();
      step(1'b1, 6, 1'b1, 3);
      chk("R8 grant", int'(alloc_grant), 1);
      chk("R8 pkt", int'(alloc_pkt), 3);
      chk("R8 free", int'(free_count), 0);
      xl_check("R8 xl", 3, 0, 1, 12);
      xl_check("R8 xl", 3, 5, 1, 17);
   endtask

   task automatic t_drain();
      for (int p = 0; p < 5; p++) step(1'b0, 0, 1'b1, p);
      chk("R6 all free", int'(free_count), 24);
      grant_expect("R2 after drain", 1, 0, 23);
      xl_check("R2 page0", 0, 0, 1, 0);
   endtask

   initial begin
      rst_n = 1'b0; alloc_req = 1'b0; alloc_pages = '0;
      rel_req = 1'b0; rel_pkt = '0; xl_pkt = '0; xl_ofs = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_err();
      t_release();
      t_deny();
      t_same_cycle();
      t_drain();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule